// File: doc/BRIEF.md
# Four-Stream Radix-4 Input Scheduling Buffer

This block sits in front of a shared radix-4 pipeline stage that serves four spatial streams. Each cycle it takes one complex sample from each of four streams. The streams run in lockstep and carry back-to-back symbols of N samples. The block re-times them so that the downstream stage sees one stream at a time. Each stream arrives as a block of N/4 cycles, and each cycle of that block presents the four samples that one radix-4 butterfly combines: n, n+N/4, n+N/2 and n+3N/4.

Storage is twelve single-port-style banks of N/4 words. A bank is refilled in the same cycle, at the same address, as soon as its old contents have been read. There are no per-stream double buffers. Instead, two small bank-location tables, one for each symbol parity, record which bank holds each quarter of each stream. In steady state, one symbol period is filled by the outgoing blocks of stream A (current symbol) followed by streams B, C and D (previous symbol), with no idle cycles.

The symbol length is chosen from 128, 512, 1024 and 2048 by a two-bit code. The code is taken while reset is held and at the last cycle of each symbol. A new length restarts the schedule.

Top module: `mstream_sched_buf`

## Requirements
- R1: `size_sel` selects N as follows: 0 gives 128, 1 gives 512, 2 gives 1024 and 3 gives 2048. It is loaded while `rst_n` is low, and the first cycle after reset carries sample 0 of every stream.
- R2: In the last quarter of every symbol (input positions 3N/4+m), the output carries stream A of that same symbol with `out_sid`=0. Lane j (bits j*SW upward) holds sample m+j*N/4.
- R3: In quarter q (q=0,1,2) of a symbol that follows a fully stored symbol of the same N, the output carries stream q+1 of the previous symbol, with `out_sid`=q+1. Lane j holds sample m+j*N/4, where m is the position within the quarter.
- R4: In quarters 0 to 2 of the first symbol after reset, and of the first symbol after a change of N, `out_valid` is 0 and `out_lanes` is all zero.
- R5: Each output cycle appears exactly two clock cycles after the input cycle whose schedule slot it belongs to.
- R6: A change of `size_sel` at any cycle other than the last cycle of a symbol has no effect.
- R7: With N unchanged, `out_valid` stays high in every cycle from the fourth quarter of the first symbol onward.
- R8: Every bank access is a write-after-read to the same address. No bank is written by two streams in one cycle. Each cycle writes three banks in the last quarter and four banks otherwise.
- R9: While in reset, and for two cycles after it, `out_valid` is 0, `out_sid` is 0 and `out_lanes` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| size_sel | input | 2 | Symbol length code (R1) |
| in_smp | input | 4*SW | One sample of each stream; stream s at bits s*SW upward (A=0 to D=3) |
| out_valid | output | 1 | Output block cycle is valid |
| out_sid | output | 2 | Stream of the current output block |
| out_lanes | output | 4*SW | Four butterfly operands; lane j at bits j*SW upward |

## Verification
Two things happen to every bank address in the same cycle: the sample leaving for the butterfly is read, and a sample of a different stream, often from the next symbol, is written into that location. Continuous streaming at all four lengths provokes this collision on every cycle. Every sample is tagged with its stream, its symbol and its index. So an early write, a wrong bank choice or a wrong table parity shows up as a lane whose tag does not match the one the bench computes arithmetically. A second overlap, between a size request and the symbol boundary, is provoked by glitching `size_sel` in mid-symbol and by changing it one symbol before a real switch.

// File: rtl/msb_pkg.sv
package msb_pkg;
  localparam int NSTR   = 4;
  localparam int NBANK  = 3 * NSTR;
  localparam int BIDX_W = $clog2(NBANK);

  typedef logic [1:0]        size_code_t;
  typedef logic [BIDX_W-1:0] bidx_t;

  // log2 of the symbol length for a size code
  function automatic int log2n_of(size_code_t code);
    case (code)
      2'd0:    return 7;
      2'd1:    return 9;
      2'd2:    return 10;
      default: return 11;
    endcase
  endfunction

  // bank used by stream s, quarter k when nothing is stored yet
  function automatic bidx_t home_bank(int s, logic [1:0] k);
    return bidx_t'(3 * s + int'(k));
  endfunction
endpackage

// File: rtl/msb_ctrl.sv
module msb_ctrl
  import msb_pkg::*;
#(
  parameter int LOG2N_MAX = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  size_code_t           size_sel,
  output logic [1:0]           quarter,
  output logic [LOG2N_MAX-3:0] offset,
  output logic                 sym_end,
  output logic                 prev_ok,
  output logic                 par,
  output size_code_t           cur_code
);
  localparam int QW = LOG2N_MAX - 2;

  logic [LOG2N_MAX-1:0] t_q;
  logic [LOG2N_MAX-1:0] nmask;
  logic [QW-1:0]        omask;
  size_code_t           code_q;
  logic                 par_q, prev_q;
  int                   l2, qsh;

  always_comb begin
    l2  = log2n_of(code_q);
    qsh = l2 - 2;
    for (int i = 0; i < LOG2N_MAX; i++) nmask[i] = (i < l2);
    for (int i = 0; i < QW; i++)        omask[i] = (i < qsh);
    quarter = 2'(t_q >> qsh);
    offset  = QW'(t_q) & omask;
    sym_end = &(t_q | ~nmask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q    <= '0;
      code_q <= size_sel;
      par_q  <= 1'b0;
      prev_q <= 1'b0;
    end else if (sym_end) begin
      t_q <= '0;
      if (size_sel != code_q) begin
        code_q <= size_sel;
        par_q  <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        par_q  <= ~par_q;
        prev_q <= 1'b1;
      end
    end else begin
      t_q <= t_q + 1'b1;
    end
  end

  assign prev_ok  = prev_q;
  assign par      = par_q;
  assign cur_code = code_q;
endmodule

// File: rtl/msb_alloc.sv
module msb_alloc
  import msb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             quarter,
  input  logic                   par,
  input  logic                   prev_ok,
  output logic [NSTR-1:0]        wr_en,
  output bidx_t [NSTR-1:0]       wr_bank,
  output bidx_t [NSTR-1:0]       rd_bank,
  output logic                   slot_live,
  output logic                   slot_valid,
  output logic [1:0]             slot_sid
);
  // location table: [symbol parity][stream][quarter] -> bank
  bidx_t      map_q [2][NSTR][NSTR];
  logic [1:0] rstr;

  always_comb begin
    wr_en      = '0;
    wr_bank    = '0;
    rd_bank    = '0;
    slot_live  = 1'b0;
    slot_valid = 1'b0;
    slot_sid   = '0;
    rstr       = 2'(quarter + 2'd1);
    if (quarter == 2'd3) begin
      // stream A of this symbol; its banks take the last quarters of B, C, D
      slot_live  = 1'b1;
      slot_valid = 1'b1;
      for (int j = 0; j < NSTR - 1; j++) rd_bank[j] = map_q[par][0][j];
      for (int s = 1; s < NSTR; s++) begin
        wr_en[s]   = 1'b1;
        wr_bank[s] = map_q[par][0][s-1];
      end
    end else if (prev_ok) begin
      // stream quarter+1 of the previous symbol; its banks take quarter k of all
      slot_valid = 1'b1;
      slot_sid   = rstr;
      for (int j = 0; j < NSTR; j++) rd_bank[j] = map_q[~par][rstr][j];
      wr_en      = '1;
      wr_bank[0] = map_q[~par][rstr][NSTR-1];
      for (int s = 1; s < NSTR; s++) wr_bank[s] = map_q[~par][rstr][s-1];
    end else begin
      wr_en = '1;
      for (int s = 0; s < NSTR; s++) wr_bank[s] = home_bank(s, quarter);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < NSTR; s++)
          for (int k = 0; k < NSTR; k++) map_q[p][s][k] <= '0;
    end else begin
      for (int s = 0; s < NSTR; s++)
        if (wr_en[s]) map_q[par][s][quarter] <= wr_bank[s];
    end
  end
endmodule

// File: rtl/msb_bank.sv
module msb_bank #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read returns the old word when written in the same cycle
  always_ff @(posedge clk) begin
    rdata <= mem[addr];
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/msb_lane_out.sv
module msb_lane_out
  import msb_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        slot_valid,
  input  logic                        slot_live,
  input  logic [1:0]                  slot_sid,
  input  bidx_t [NSTR-1:0]            rd_bank,
  input  logic [SW-1:0]               live_smp,
  input  logic [NBANK-1:0][SW-1:0]    bank_rd,
  output logic                        out_valid,
  output logic [1:0]                  out_sid,
  output logic [NSTR*SW-1:0]          out_lanes
);
  logic                 v1, live1;
  logic [1:0]           sid1;
  bidx_t [NSTR-1:0]     sel1;
  logic [SW-1:0]        smp1;
  logic [NSTR*SW-1:0]   lanes_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      live1 <= 1'b0;
      sid1  <= '0;
      sel1  <= '0;
      smp1  <= '0;
    end else begin
      v1    <= slot_valid;
      live1 <= slot_live;
      sid1  <= slot_sid;
      sel1  <= rd_bank;
      smp1  <= live_smp;
    end
  end

  always_comb begin
    for (int j = 0; j < NSTR; j++) begin
      if (j == NSTR - 1 && live1) lanes_c[j*SW +: SW] = smp1;
      else                        lanes_c[j*SW +: SW] = bank_rd[sel1[j]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sid   <= '0;
      out_lanes <= '0;
    end else begin
      out_valid <= v1;
      out_sid   <= v1 ? sid1 : 2'd0;
      out_lanes <= v1 ? lanes_c : '0;
    end
  end
endmodule

// File: rtl/mstream_sched_buf.sv
module mstream_sched_buf
  import msb_pkg::*;
#(
  parameter int SW        = 32,
  parameter int LOG2N_MAX = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           size_sel,
  input  logic [NSTR*SW-1:0]   in_smp,
  output logic                 out_valid,
  output logic [1:0]           out_sid,
  output logic [NSTR*SW-1:0]   out_lanes
);
  localparam int QW = LOG2N_MAX - 2;

  logic [1:0]              quarter;
  logic [QW-1:0]           offset;
  logic                    sym_end, prev_ok, par;
  size_code_t              cur_code;
  logic [NSTR-1:0]         wr_en;
  bidx_t [NSTR-1:0]        wr_bank;
  bidx_t [NSTR-1:0]        rd_bank;
  logic                    slot_live, slot_valid;
  logic [1:0]              slot_sid;
  logic [NBANK-1:0]        bank_we;
  logic [NBANK-1:0][SW-1:0] bank_wd;
  logic [NBANK-1:0][SW-1:0] bank_rd;

  msb_ctrl #(.LOG2N_MAX(LOG2N_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel),
    .quarter(quarter), .offset(offset), .sym_end(sym_end),
    .prev_ok(prev_ok), .par(par), .cur_code(cur_code)
  );

  msb_alloc u_alloc (
    .clk(clk), .rst_n(rst_n), .quarter(quarter), .par(par), .prev_ok(prev_ok),
    .wr_en(wr_en), .wr_bank(wr_bank), .rd_bank(rd_bank),
    .slot_live(slot_live), .slot_valid(slot_valid), .slot_sid(slot_sid)
  );

  // route each stream's sample to the bank chosen for it
  always_comb begin
    bank_we = '0;
    bank_wd = '0;
    for (int b = 0; b < NBANK; b++)
      for (int s = 0; s < NSTR; s++)
        if (wr_en[s] && wr_bank[s] == bidx_t'(b)) begin
          bank_we[b] = 1'b1;
          bank_wd[b] = in_smp[s*SW +: SW];
        end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    msb_bank #(.AW(QW), .DW(SW)) u_bank (
      .clk(clk), .we(bank_we[g]), .addr(offset),
      .wdata(bank_wd[g]), .rdata(bank_rd[g])
    );
  end

  msb_lane_out #(.SW(SW)) u_out (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_live(slot_live),
    .slot_sid(slot_sid), .rd_bank(rd_bank), .live_smp(in_smp[SW-1:0]),
    .bank_rd(bank_rd), .out_valid(out_valid), .out_sid(out_sid),
    .out_lanes(out_lanes)
  );
endmodule

// File: rtl/msb_checker.sv
module msb_checker
  import msb_pkg::*;
#(
  parameter int SW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 slot_live,
  input logic                 slot_valid,
  input logic [1:0]           slot_sid,
  input logic                 sym_end,
  input size_code_t           cur_code,
  input logic [NSTR-1:0]      wr_en,
  input bidx_t [NSTR-1:0]     wr_bank,
  input logic [NBANK-1:0]     bank_we,
  input logic                 out_valid,
  input logic [1:0]           out_sid,
  input logic [NSTR*SW-1:0]   out_lanes
);
  logic clash;

  always_comb begin
    clash = 1'b0;
    for (int i = 0; i < NSTR; i++)
      for (int j = i + 1; j < NSTR; j++)
        if (wr_en[i] && wr_en[j] && wr_bank[i] == wr_bank[j]) clash = 1'b1;
  end

  // R2
  live_block_sid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_live |=> ##1 (out_valid && out_sid == 2'd0));

  // R3
  prior_block_sid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !slot_live) |=> ##1 (out_valid && out_sid == $past(slot_sid, 2)));

  // R4
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |=> ##1 (!out_valid && out_lanes == '0));

  // R6
  size_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_code) |-> $past(sym_end));

  // R8
  bank_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clash);

  // R8
  bank_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_we) == (slot_live ? 3 : 4));
endmodule

bind mstream_sched_buf msb_checker #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_live(slot_live), .slot_valid(slot_valid),
  .slot_sid(slot_sid), .sym_end(sym_end), .cur_code(cur_code),
  .wr_en(wr_en), .wr_bank(wr_bank), .bank_we(bank_we),
  .out_valid(out_valid), .out_sid(out_sid), .out_lanes(out_lanes)
);

// File: tb/mstream_sched_buf_tb.sv
`timescale 1ns/1ps
module mstream_sched_buf_tb;
  localparam int SW = 32;
  localparam int NS = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        size_sel = 2'd0;
  logic [NS*SW-1:0]  in_smp = '0;
  logic              out_valid;
  logic [1:0]        out_sid;
  logic [NS*SW-1:0]  out_lanes;

  int checks = 0, fails = 0, gsym = 0;
  bit done = 1'b0, release_pending = 1'b0;

  logic             p1_v = 1'b0, p2_v = 1'b0;
  logic [1:0]       p1_sid = '0, p2_sid = '0;
  logic [NS*SW-1:0] p1_l = '0, p2_l = '0;
  string            p1_tag = "R9", p2_tag = "R9";

  always #2 clk = ~clk;

  mstream_sched_buf #(.SW(SW), .LOG2N_MAX(11)) u_dut (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .in_smp(in_smp),
    .out_valid(out_valid), .out_sid(out_sid), .out_lanes(out_lanes)
  );

  function automatic logic [SW-1:0] smp(int s, int sy, int n);
    return {4'(s), 8'(sy), 4'hA, 16'(n)};
  endfunction

  // R1: code to length
  function automatic int nlen(int code);
    case (code)
      0: return 128;
      1: return 512;
      2: return 1024;
      default: return 2048;
    endcase
  endfunction

  // check the slot from two cycles ago (R5), then queue the new one
  task automatic tick(input logic v, input logic [1:0] sid,
                      input logic [NS*SW-1:0] lanes, input string tag);
    checks++;
    if (out_valid !== p2_v || out_sid !== (p2_v ? p2_sid : 2'd0) || out_lanes !== p2_l) begin
      fails++;
      $display("FAIL %s: actual v=%0b sid=%0d lanes=%h expected v=%0b sid=%0d lanes=%h",
               p2_tag, out_valid, out_sid, out_lanes, p2_v, p2_sid, p2_l);
    end
    p2_v = p1_v; p2_sid = p1_sid; p2_l = p1_l; p2_tag = p1_tag;
    p1_v = v;    p1_sid = sid;    p1_l = lanes; p1_tag = tag;
  endtask

  task automatic run_cfg(input int code, input int nsym, input int next_code, input bit glitch);
    int n = nlen(code);
    int q = n / 4;
    for (int sy = 0; sy < nsym; sy++) begin
      for (int t = 0; t < n; t++) begin
        logic             v;
        logic [1:0]       sid;
        logic [NS*SW-1:0] lanes;
        string            tag;
        int               k = t / q;
        int               o = t % q;
        @(negedge clk);
        if (release_pending) begin rst_n = 1'b1; release_pending = 1'b0; end
        if (sy == nsym - 1 && t == 0) size_sel = 2'(next_code);
        // R6: mid-symbol glitch on the size code
        if (glitch && sy == 0 && t == q)     size_sel = 2'(code ^ 1);
        if (glitch && sy == 0 && t == q + 5) size_sel = 2'(code);
        for (int s = 0; s < NS; s++) in_smp[s*SW +: SW] = smp(s, gsym, t);
        lanes = '0;
        if (k == 3) begin
          v = 1'b1; sid = 2'd0; tag = glitch ? "R1 R2 R5 R6" : "R1 R2 R5";
          for (int j = 0; j < NS; j++) lanes[j*SW +: SW] = smp(0, gsym, o + j * q);
        end else if (sy >= 1) begin
          v = 1'b1; sid = 2'(k + 1); tag = glitch ? "R3 R5 R7 R8 R6" : "R3 R5 R7 R8";
          for (int j = 0; j < NS; j++) lanes[j*SW +: SW] = smp(k + 1, gsym - 1, o + j * q);
        end else begin
          v = 1'b0; sid = 2'd0; tag = "R4";
        end
        tick(v, sid, lanes, tag);
      end
      gsym++;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    size_sel = 2'd0;
    // R9: reset state
    repeat (5) begin
      @(negedge clk);
      tick(1'b0, 2'd0, '0, "R9");
    end
    release_pending = 1'b1;
    run_cfg(0, 4, 1, 1'b0);
    run_cfg(1, 3, 2, 1'b1);
    run_cfg(2, 3, 3, 1'b0);
    run_cfg(3, 3, 0, 1'b1);
    run_cfg(0, 3, 0, 1'b0);
    repeat (2) begin
      @(negedge clk);
      tick(1'b0, 2'd0, '0, "flush");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R5: watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule